// File: doc/BRIEF.md
# Countdown Watchdog with Domain Reset Control

This block is a countdown watchdog timer on a small synchronous register bus. A programmable prescaler divides the reference clock into a periodic tick. A 24-bit down-counter loses one count per tick while the watchdog is enabled and not paused. Software keeps the system alive by writing a fresh value to the load register before the counter runs out.

When the counter sits at zero with the watchdog enabled, the block fires. Software can also make it fire at once through a trigger bit. Firing sends a four-cycle reset pulse to every power domain chosen by a 17-bit select mask. It also clears the enable bit and records the cause in a sticky reason register. Three pause bits let counting stop while core 0 is halted for debug, while core 1 is halted for debug, or while the JTAG port owns the bus. Each pause bit acts only when its matching input is high.

Register map, one 32-bit word per address: 0 control (bit 0 enable, bit 1 pause on core-0 debug, bit 2 pause on core-1 debug, bit 3 pause on JTAG, bit 4 trigger), 1 counter (write loads, read returns the live count in bits 23:0), 2 tick (bits 7:0 divide count N, bit 8 tick enable), 3 domain select (bits 16:0), 4 reason (bit 0 timeout, bit 1 forced; write 1 to clear).

Top module: `wdog_top`

## Requirements
- R1: With tick enable set and a divide count N of 1 to 255, the counter drops by one every N clock cycles. After the tick register is written while the prescaler is idle, with counter value L and enable already set, domainRst first goes high L*N+1 clock edges after the tick-register write edge.
- R2: A write to address 1 sets the counter to bits 23:0 of the write data at that clock edge, and address 1 reads back the current count.
- R3: With control bit 0 clear, the counter holds its value whatever the tick does.
- R4: Firing drives domainRst high for exactly 4 consecutive cycles, starting one cycle after the cycle in which the enabled counter reads zero.
- R5: While a pause bit (control bits 1, 2, 3 for dbgHalt0, dbgHalt1, jtagActive) is set and its matching input is high, the counter does not change and no timeout occurs.
- R6: A high debug or JTAG input whose pause bit is clear has no effect on counting or timeout timing.
- R7: Writing 1 to control bit 4 starts the reset pulse at that write edge, whatever the count is, and bit 4 always reads back as 0.
- R8: After firing, control bit 0 reads 0 and the counter stays at zero until it is reloaded.
- R9: The reason register holds 01 after a timeout and 10 after a forced trigger. The value stays until a write of 1 to a bit clears that bit.
- R10: During the pulse, domainRst equals the domain select mask held at the moment of firing. Unselected domains stay low.
- R11: After reset: control 0, counter 0, tick 0, domain select 0x1FFFF, reason 0. Unused bits and unused addresses 5 to 7 read 0.
- R12: With tick enable set but a divide count of 0, no tick occurs and the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Word address |
| busWe | input | 1 | Write enable, sampled at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| dbgHalt0 | input | 1 | Core 0 halted for debug |
| dbgHalt1 | input | 1 | Core 1 halted for debug |
| jtagActive | input | 1 | JTAG port accessing the bus |
| domainRst | output | 17 | Reset request, one bit per domain |

## Verification
The hardest thing to check from the ports is when the timeout lands, because it depends on the prescaler phase, and that phase cannot be read. The stimulus sets a known phase by switching the tick off, loading the counter and setting enable, and only then switching the tick on. The first pulse cycle is then fixed at L*N+1 edges after that write. The stimulus runs this sequence under several divide counts and pause settings. Paused rows must show no pulse at all and an unchanged count when read back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 24;
  localparam int TICK_W = 8;
  localparam int DOM_N  = 17;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TICK   = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOMSEL = 3'd3;
  localparam logic [ADDR_W-1:0] A_REASON = 3'd4;

  localparam logic [DOM_N-1:0] DOMSEL_RST = {DOM_N{1'b1}};

  typedef struct packed {
    logic              tickEn;
    logic [TICK_W-1:0] tickCycles;
    logic              loadWr;
    logic [CNT_W-1:0]  loadVal;
    logic              countEn;
    logic              fire;
    logic [DOM_N-1:0]  domSel;
  } wdogStrb_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStrb_t        strb,
  output logic [CNT_W-1:0] count,
  output logic             cntZero,
  output logic [DOM_N-1:0] domainRst
);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic [TICK_W-1:0]  tickCnt;
  logic               tick;
  logic [PULSE_W-1:0] pulseCnt;
  logic [DOM_N-1:0]   heldMask;

  // prescaler: a one-cycle tick every tickCycles reference cycles
  assign tick = strb.tickEn && (strb.tickCycles != '0) &&
                (tickCnt == strb.tickCycles - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!strb.tickEn || tick) begin
      tickCnt <= '0;
    end else if (strb.tickCycles != '0) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // down-counter, saturates at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.loadWr) begin
      count <= strb.loadVal;
    end else if (strb.countEn && tick && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign cntZero = (count == '0);

  // reset pulse shaper
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      heldMask <= '0;
    end else if (strb.fire) begin
      pulseCnt <= PULSE_W'(PULSE_LEN);
      heldMask <= strb.domSel;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    assign domainRst[d] = heldMask[d] && (pulseCnt != '0);
  end

  a_r4_pulse_mask: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> domainRst == $past(strb.domSel));

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadWr |=> (count == $past(count)) || (count == $past(count) - 24'd1));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.loadWr) |=> $stable(count));

  a_r8_stay_zero: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !strb.loadWr) |=> count == '0);

  a_r12_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickCycles == '0) |-> !tick);
endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dbgHalt0,
  input  logic              dbgHalt1,
  input  logic              jtagActive,
  input  logic [CNT_W-1:0]  count,
  input  logic              cntZero,
  output wdogStrb_t         strb
);
  logic              enable;
  logic [2:0]        pauseSel;
  logic              tickEn;
  logic [TICK_W-1:0] tickCycles;
  logic [DOM_N-1:0]  domSel;
  logic [1:0]        reason;

  logic ctrlWr, loadWr, tickWr, domWr, reasonWr, trigWr, timeoutHit, fire;
  logic [2:0] haltIn, pauseHit;

  assign ctrlWr   = busWe && busAddr == A_CTRL;
  assign loadWr   = busWe && busAddr == A_LOAD;
  assign tickWr   = busWe && busAddr == A_TICK;
  assign domWr    = busWe && busAddr == A_DOMSEL;
  assign reasonWr = busWe && busAddr == A_REASON;
  assign trigWr   = ctrlWr && busWdata[4];

  assign haltIn = {jtagActive, dbgHalt1, dbgHalt0};
  for (genvar p = 0; p < 3; p++) begin : g_pause
    assign pauseHit[p] = pauseSel[p] && haltIn[p];
  end

  assign timeoutHit = enable && cntZero && !loadWr;
  assign fire       = trigWr || timeoutHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable     <= 1'b0;
      pauseSel   <= '0;
      tickEn     <= 1'b0;
      tickCycles <= '0;
      domSel     <= DOMSEL_RST;
      reason     <= '0;
    end else begin
      if (fire)        enable <= 1'b0;
      else if (ctrlWr) enable <= busWdata[0];
      if (ctrlWr) pauseSel <= busWdata[3:1];
      if (tickWr) begin
        tickCycles <= busWdata[TICK_W-1:0];
        tickEn     <= busWdata[TICK_W];
      end
      if (domWr) domSel <= busWdata[DOM_N-1:0];
      if (fire)          reason <= trigWr ? 2'b10 : 2'b01;
      else if (reasonWr) reason <= reason & ~busWdata[1:0];
    end
  end

  always_comb begin
    strb            = '0;
    strb.tickEn     = tickEn;
    strb.tickCycles = tickCycles;
    strb.loadWr     = loadWr;
    strb.loadVal    = busWdata[CNT_W-1:0];
    strb.countEn    = enable && (pauseHit == '0);
    strb.fire       = fire;
    strb.domSel     = domSel;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL:   busRdata[3:0] = {pauseSel, enable};
      A_LOAD:   busRdata[CNT_W-1:0] = count;
      A_TICK:   busRdata[TICK_W:0] = {tickEn, tickCycles};
      A_DOMSEL: busRdata[DOM_N-1:0] = domSel;
      A_REASON: busRdata[1:0] = reason;
      default:  busRdata = '0;
    endcase
  end

  a_r7_trigger: assert property (@(posedge clk) disable iff (!rstN)
    trigWr |=> !enable && reason == 2'b10);

  a_r8_disable: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> !enable && reason == 2'b01);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!fire && !reasonWr) |=> $stable(reason));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              dbgHalt0,
  input  logic              dbgHalt1,
  input  logic              jtagActive,
  output logic [DOM_N-1:0]  domainRst
);
  wdogStrb_t        strb;
  logic [CNT_W-1:0] count;
  logic             cntZero;

  wdog_control u_control (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .dbgHalt0(dbgHalt0),
    .dbgHalt1(dbgHalt1), .jtagActive(jtagActive), .count(count),
    .cntZero(cntZero), .strb(strb)
  );

  wdog_datapath #(.PULSE_LEN(PULSE_LEN)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .count(count),
    .cntZero(cntZero), .domainRst(domainRst)
  );
endmodule

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        dbgHalt0 = 1'b0, dbgHalt1 = 1'b0, jtagActive = 1'b0;
  logic [16:0] domainRst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_top u_wdog_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .dbgHalt0(dbgHalt0),
    .dbgHalt1(dbgHalt1), .jtagActive(jtagActive), .domainRst(domainRst)
  );

  typedef struct packed {
    logic [7:0]  n;
    logic [23:0] l;
    logic [2:0]  pm;
    logic [2:0]  pin;
    logic [16:0] mask;
    logic        fire;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 24'd5, 3'b000, 3'b000, 17'h1FFFC, 1'b1},
    '{8'd3, 24'd4, 3'b000, 3'b111, 17'h00001, 1'b1},
    '{8'd2, 24'd1, 3'b000, 3'b000, 17'h10000, 1'b1},
    '{8'd5, 24'd2, 3'b001, 3'b010, 17'h0AAAA, 1'b1},
    '{8'd2, 24'd3, 3'b100, 3'b100, 17'h1FFFF, 1'b0},
    '{8'd1, 24'd6, 3'b010, 3'b010, 17'h1FFFF, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // counts edges until domainRst rises, then the pulse width
  task automatic measure(input int lim, output int lat, output int wid,
                         output logic [16:0] seen);
    lat = 0; wid = 0; seen = '0;
    while (domainRst == '0 && lat < lim) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    seen = domainRst;
    while (domainRst != '0 && wid < 10) begin
      wid++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    int lat, wid, expLat;
    logic [16:0] seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(3'd0, d); chk(d == 32'h0, "R11 ctrl", d, 0);
    rd(3'd1, d); chk(d == 32'h0, "R11 count", d, 0);
    rd(3'd2, d); chk(d == 32'h0, "R11 tick", d, 0);
    rd(3'd3, d); chk(d == 32'h1FFFF, "R11 domsel", d, 32'h1FFFF);
    rd(3'd4, d); chk(d == 32'h0, "R11 reason", d, 0);
    rd(3'd6, d); chk(d == 32'h0, "R11 unused addr", d, 0);
    chk(domainRst == '0, "R11 domainRst", domainRst, 0);

    // table: R1 R4 R5 R6 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      wr(3'd2, 32'h0);
      wr(3'd3, {15'h0, t.mask});
      wr(3'd1, {8'h0, t.l});
      {jtagActive, dbgHalt1, dbgHalt0} = t.pin;
      wr(3'd0, {28'h0, t.pm, 1'b1});
      wr(3'd2, {23'h0, 1'b1, t.n});
      expLat = int'(t.l) * int'(t.n) + 1;
      measure(t.fire ? expLat + 5 : 60, lat, wid, seen);
      if (t.fire) begin
        chk(lat == expLat, "R1 timeout latency", lat, expLat);
        chk(wid == 4, "R4 pulse width", wid, 4);
        chk(seen == t.mask, "R10 domain mask", seen, t.mask);
        rd(3'd0, d); chk(d[0] == 1'b0, "R8 enable cleared", d, 0);
        rd(3'd1, d); chk(d == 32'h0, "R8 count held at zero", d, 0);
        rd(3'd4, d); chk(d == 32'h1, "R9 reason timeout", d, 1);
      end else begin
        chk(lat == 60 && wid == 0, "R5 paused no fire", lat, 60);
        rd(3'd1, d); chk(d == {8'h0, t.l}, "R5 paused count", d, t.l);
      end
      {jtagActive, dbgHalt1, dbgHalt0} = 3'b000;
      wr(3'd0, 32'h0);
    end

    // R9 write-one-to-clear, sticky
    wr(3'd4, 32'h0);
    rd(3'd4, d); chk(d == 32'h1, "R9 zero write keeps", d, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk(d == 32'h0, "R9 w1c", d, 0);

    // R2 feed, R3 disabled hold
    wr(3'd2, 32'h0);
    wr(3'd1, 32'd10);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h101);
    waitCyc(3);
    wr(3'd1, 32'd20);
    rd(3'd1, d); chk(d == 32'd20, "R2 load immediate", d, 20);
    wr(3'd0, 32'h0);
    rd(3'd1, d);
    waitCyc(10);
    begin
      logic [31:0] d2;
      rd(3'd1, d2); chk(d2 == d, "R3 disabled holds", d2, d);
    end

    // R12 divide count zero
    wr(3'd2, 32'h100);
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h1);
    waitCyc(20);
    rd(3'd1, d); chk(d == 32'd5, "R12 no tick at N=0", d, 5);
    chk(domainRst == '0, "R12 no fire", domainRst, 0);

    // R7 forced trigger with nonzero count
    wr(3'd3, 32'h000F0);
    wr(3'd0, 32'h11);
    measure(3, lat, wid, seen);
    chk(lat == 0, "R7 immediate pulse", lat, 0);
    chk(wid == 4, "R7 pulse width", wid, 4);
    chk(seen == 17'h000F0, "R10 forced mask", seen, 32'hF0);
    rd(3'd0, d); chk(d == 32'h0, "R7 trigger reads zero", d, 0);
    rd(3'd4, d); chk(d == 32'h2, "R9 reason forced", d, 2);
    rd(3'd1, d); chk(d == 32'd5, "R7 count untouched", d, 5);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule